// File: doc/BRIEF.md
# Four-Slot Successive-Approximation Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation converter. A write to its control register starts a frame of four conversions. Each conversion closes the sample switch on the selected analog channel, then tries one bit at a time, from the most significant bit down. For each bit it drives a trial code to an external DAC and comparator and keeps or drops the bit according to the comparator's answer. The finished code of conversion k goes into result slot k, and a completion flag rises with the fourth code.

The control byte selects the channel or channel group and the single- or multi-channel mode. It also selects whether the frame repeats without a gap or stops after one pass, and it carries a power enable that gates all activity. Software reads the four slots and the flag through a plain combinational read port. Every count advances only on cycles where the clock-enable tick is high. The analog array, the bias circuits and the comparator itself are outside the block.

Control byte layout: bit 7 enables power, bit 5 enables repeat, bit 4 selects multi-channel mode, and bits 3:0 hold the channel. Bit 6 is unused.

Top module: `sar_seq_top`

## Requirements
- R1: One frame is exactly four conversions. Conversion k (k = 0..3) writes result slot k, read with `rd_sel` = k. After a frame on a single channel, all four slots hold that channel's code.
- R2: With `tick` held high, slot k is updated at the edge 32·(k+1) cycles after the write edge and is unchanged one cycle earlier.
- R3: In cycles 0 to 11 of each conversion, `sample_o` is 1 and `trial_o` is 0. From cycle 12 on, `sample_o` is 0.
- R4: Bits are resolved from bit 7 to bit 0, taking 2 cycles per bit, so `trial_o` = 0x80 in cycle 12. On the second cycle of each pair the bit is kept if `cmp_i` = 1 (input at or above the trial level) and cleared otherwise. An ideal comparator therefore yields the input code exactly, including 0x00 and 0xFF.
- R5: `done_o` is set on the same edge that writes slot 3, and stays 0 after slots 0 to 2 are written.
- R6: With bit 4 = 0, all four conversions use channel bits 3:0. With bit 4 = 1, conversion k uses channel {bits 3:2, k}.
- R7: With bit 5 = 1, the next frame starts sampling in cycle 128 with no gap. With bit 5 = 0, the block goes idle after slot 3 (`sample_o` = 0, `trial_o` = 0) and the slots keep their codes.
- R8: A write with bit 7 = 0 stops all activity on the next cycle. No slot changes afterwards, and `done_o` reads 0.
- R9: Any control write, including one in the middle of a frame, clears `done_o` and restarts the frame at conversion 0, with the R2 timing counted from that write.
- R10: `rd_sel` = 4 returns `done_o` in bit 7 and zeros elsewhere. Reading it does not clear the flag; only a control write does.
- R11: While `tick` is 0, the frame does not advance: the sample phase holds and no slot is written. Counting resumes when `tick` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable for all sequencing counts |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control byte |
| rd_sel | input | 3 | Read select: 0..3 result slots, 4 status |
| rd_data | output | 8 | Read data (combinational) |
| sample_o | output | 1 | Sample switch control |
| chan_o | output | 4 | Channel being converted |
| trial_o | output | 8 | Trial code to the DAC |
| cmp_i | input | 1 | Comparator decision: 1 when input ≥ trial level |
| done_o | output | 1 | Frame-complete flag |

## Verification
All timing is measured from the edge that captures the control write, which is cycle 0. The sample switch must be open by cycle 12, with 0x80 on the trial output in that same cycle. Slot k must change exactly at cycle 32·(k+1), and the flag must appear at cycle 128. The bench steps a known number of falling edges after each write and samples at the expected cycle and one cycle before it, so an early or late update is caught. Stall tests hold the tick low for a fixed count before stepping, and abort tests recount from the second write.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Control byte as written through the register port
  typedef struct packed {
    logic       pwr;
    logic       spare;
    logic       scan;
    logic       multi;
    logic [3:0] chan;
  } ctl_t;

  localparam int CTL_W  = $bits(ctl_t);
  localparam int CHAN_W = 4;
endpackage

// File: rtl/sar_timing.sv
module sar_timing #(
  parameter int NCONV    = 4,
  parameter int CONV_CYC = 32,
  localparam int CW = $clog2(CONV_CYC),
  localparam int NW = $clog2(NCONV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          halt,
  input  logic          scan,
  output logic          run,
  output logic [CW-1:0] cyc,
  output logic [NW-1:0] conv,
  output logic          conv_end,
  output logic          done
);
  assign conv_end = run && tick && (cyc == CW'(CONV_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cyc  <= '0;
      conv <= '0;
      done <= 1'b0;
    end else if (start || halt) begin
      run  <= start;
      cyc  <= '0;
      conv <= '0;
      done <= 1'b0;
    end else if (run && tick) begin
      if (conv_end) begin
        cyc <= '0;
        if (conv == NW'(NCONV - 1)) begin
          conv <= '0;
          done <= 1'b1;
          run  <= scan;
        end else begin
          conv <= conv + 1'b1;
        end
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W    = 8,
  parameter int SAMP_CYC = 12,
  parameter int CW       = 5,
  localparam int BIT_END = SAMP_CYC + 2 * RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CW-1:0]    cyc,
  input  logic             cmp_i,
  output logic             sample,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] acc
);
  logic [CW-1:0]    off;
  logic             in_bits;
  logic [RES_W-1:0] mask;

  assign off     = cyc - CW'(SAMP_CYC);
  assign sample  = run && (cyc < CW'(SAMP_CYC));
  assign in_bits = run && (cyc >= CW'(SAMP_CYC)) && (cyc < CW'(BIT_END));
  assign mask    = {1'b1, {(RES_W-1){1'b0}}} >> off[CW-1:1];
  assign trial   = in_bits ? (acc | mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (run && tick) begin
      if (sample)
        acc <= '0;
      else if (in_bits && off[0])
        acc <= cmp_i ? (acc | mask) : (acc & ~mask);
    end
  end
endmodule

// File: rtl/sar_results.sv
module sar_results #(
  parameter int NCONV = 4,
  parameter int RES_W = 8,
  localparam int NW = $clog2(NCONV),
  localparam int SW = $clog2(NCONV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [NW-1:0]    conv,
  input  logic [RES_W-1:0] code,
  input  logic             done,
  input  logic [SW-1:0]    rd_sel,
  output logic [RES_W-1:0] rd_data
);
  logic [RES_W-1:0] slots [NCONV];

  for (genvar k = 0; k < NCONV; k++) begin : g_slot
    logic [RES_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr && (conv == NW'(k)))
        q <= code;
    end
    assign slots[k] = q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel < SW'(NCONV))
      rd_data = slots[rd_sel[NW-1:0]];
    else if (rd_sel == SW'(NCONV))
      rd_data = {done, {(RES_W-1){1'b0}}};
  end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int NCONV    = 4,
  parameter int RES_W    = 8,
  parameter int SAMP_CYC = 12,
  parameter int CONV_CYC = 32,
  localparam int CW = $clog2(CONV_CYC),
  localparam int NW = $clog2(NCONV),
  localparam int SW = $clog2(NCONV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic [SW-1:0]     rd_sel,
  output logic [RES_W-1:0]  rd_data,
  output logic              sample_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [RES_W-1:0]  trial_o,
  input  logic              cmp_i,
  output logic              done_o
);
  ctl_t             ctl;
  ctl_t             wr_ctl;
  logic             run;
  logic [CW-1:0]    cyc;
  logic [NW-1:0]    conv;
  logic             conv_end;
  logic [RES_W-1:0] acc;

  assign wr_ctl = ctl_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl <= '0;
    else if (wr_en)
      ctl <= wr_ctl;
  end

  assign chan_o = ctl.multi ? {ctl.chan[CHAN_W-1:NW], conv} : ctl.chan;

  sar_timing #(.NCONV(NCONV), .CONV_CYC(CONV_CYC)) u_timing (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start(wr_en && wr_ctl.pwr), .halt(wr_en && !wr_ctl.pwr),
    .scan(ctl.scan), .run(run), .cyc(cyc), .conv(conv),
    .conv_end(conv_end), .done(done_o)
  );

  sar_approx #(.RES_W(RES_W), .SAMP_CYC(SAMP_CYC), .CW(CW)) u_approx (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cyc(cyc),
    .cmp_i(cmp_i), .sample(sample_o), .trial(trial_o), .acc(acc)
  );

  sar_results #(.NCONV(NCONV), .RES_W(RES_W)) u_results (
    .clk(clk), .rst_n(rst_n), .wr(conv_end), .conv(conv), .code(acc),
    .done(done_o), .rd_sel(rd_sel), .rd_data(rd_data)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             run,
  input logic             sample_o,
  input logic [RES_W-1:0] trial_o,
  input logic             done_o
);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  AST_SAMPLE_NO_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (trial_o == '0)); // R3
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_o) && !$past(wr_en)) |-> (trial_o == MSB_ONLY)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!sample_o && trial_o == '0)); // R8
  AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !done_o); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wr_en) |=> done_o); // R10
endmodule

bind sar_seq_top sar_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .run(run),
  .sample_o(sample_o), .trial_o(trial_o), .done_o(done_o)
);

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_sel = 3'd0;
  logic [7:0] rd_data;
  logic       sample_o;
  logic [3:0] chan_o;
  logic [7:0] trial_o;
  logic       cmp_i;
  logic       done_o;
  logic [7:0] analog [16];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // Ideal comparator: high when the selected input is at or above the trial level
  assign cmp_i = (analog[chan_o] >= trial_o);

  sar_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sample_o(sample_o), .chan_o(chan_o),
    .trial_o(trial_o), .cmp_i(cmp_i), .done_o(done_o)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1", "reset done", {7'd0, done_o}, 8'h00);
    check("R3", "reset sample", {7'd0, sample_o}, 8'h00);
    check("R4", "reset trial", trial_o, 8'h00);
    rd(3'd0, v); check("R1", "reset slot0", v, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] v;
    analog[5] = 8'hA7;
    wr(8'h85);
    check("R3", "sample cycle0", {7'd0, sample_o}, 8'h01);
    check("R6", "single chan", {4'd0, chan_o}, 8'h05);
    step(11); check("R3", "sample cycle11", {7'd0, sample_o}, 8'h01);
    check("R3", "trial in sample", trial_o, 8'h00);
    step(1);  check("R3", "sample cycle12", {7'd0, sample_o}, 8'h00);
    check("R4", "trial msb first", trial_o, 8'h80);
    step(19); rd(3'd0, v); check("R2", "slot0 at 31", v, 8'h00);
    step(1);  rd(3'd0, v); check("R2", "slot0 at 32", v, 8'hA7);
    check("R5", "done after conv0", {7'd0, done_o}, 8'h00);
    step(95); check("R5", "done at 127", {7'd0, done_o}, 8'h00);
    rd(3'd3, v); check("R2", "slot3 at 127", v, 8'h00);
    step(1);  check("R5", "done at 128", {7'd0, done_o}, 8'h01);
    for (int k = 0; k < 4; k++) begin
      rd(3'(k), v); check("R1", "slot after frame", v, 8'hA7);
    end
    check("R7", "idle after frame", {7'd0, sample_o}, 8'h00);
  endtask

  task automatic t_multi();
    logic [7:0] v;
    analog[8] = 8'h00; analog[9] = 8'hFF; analog[10] = 8'h80; analog[11] = 8'h5B;
    wr(8'h99);
    check("R9", "write clears done", {7'd0, done_o}, 8'h00);
    check("R6", "multi chan conv0", {4'd0, chan_o}, 8'h08);
    step(32); check("R6", "multi chan conv1", {4'd0, chan_o}, 8'h09);
    step(96);
    rd(3'd0, v); check("R4", "code 00", v, 8'h00);
    rd(3'd1, v); check("R4", "code FF", v, 8'hFF);
    rd(3'd2, v); check("R4", "code 80", v, 8'h80);
    rd(3'd3, v); check("R6", "code 5B", v, 8'h5B);
    rd(3'd4, v); check("R10", "status read 1", v, 8'h80);
    rd(3'd4, v); check("R10", "status read 2", v, 8'h80);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    analog[8] = 8'h44;
    step(200);
    check("R7", "stopped sample", {7'd0, sample_o}, 8'h00);
    check("R7", "stopped trial", trial_o, 8'h00);
    rd(3'd0, v); check("R7", "slots kept", v, 8'h00);
    check("R10", "flag held", {7'd0, done_o}, 8'h01);
  endtask

  task automatic t_scan();
    logic [7:0] v;
    analog[2] = 8'h11;
    wr(8'hA2);
    step(128);
    rd(3'd3, v); check("R7", "scan frame1 slot3", v, 8'h11);
    check("R7", "scan done", {7'd0, done_o}, 8'h01);
    check("R7", "scan restarts", {7'd0, sample_o}, 8'h01);
    analog[2] = 8'h66;
    step(128);
    for (int k = 0; k < 4; k++) begin
      rd(3'(k), v); check("R7", "scan frame2", v, 8'h66);
    end
  endtask

  task automatic t_abort();
    logic [7:0] v;
    step(50);
    analog[1] = 8'h3C;
    wr(8'h81);
    check("R9", "abort clears done", {7'd0, done_o}, 8'h00);
    step(31); rd(3'd0, v); check("R9", "slot0 before", v, 8'h66);
    step(1);  rd(3'd0, v); check("R9", "slot0 restart", v, 8'h3C);
    rd(3'd1, v); check("R9", "slot1 untouched", v, 8'h66);
    step(96); rd(3'd3, v); check("R9", "slot3 new", v, 8'h3C);
  endtask

  task automatic t_power();
    logic [7:0] v;
    wr(8'h05);
    check("R8", "off sample", {7'd0, sample_o}, 8'h00);
    analog[5] = 8'h12;
    step(200);
    rd(3'd0, v); check("R8", "off slot kept", v, 8'h3C);
    check("R8", "off done", {7'd0, done_o}, 8'h00);
    check("R8", "off trial", trial_o, 8'h00);
  endtask

  task automatic t_tick();
    logic [7:0] v;
    @(negedge clk); tick = 1'b0;
    wr(8'h85);
    step(50);
    check("R11", "stall sample", {7'd0, sample_o}, 8'h01);
    rd(3'd0, v); check("R11", "stall slot", v, 8'h3C);
    tick = 1'b1;
    step(31); rd(3'd0, v); check("R11", "resume slot at 31", v, 8'h3C);
    step(1);  rd(3'd0, v); check("R11", "resume slot at 32", v, 8'h12);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) analog[i] = 8'h00;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_single();
    t_multi();
    t_stop();
    t_scan();
    t_abort();
    t_power();
    t_tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule